// File: doc/BRIEF.md
# Timebase-Bit Escalating Watchdog

This block is a per-core watchdog. It keeps a 64-bit timebase that counts up by one on each cycle where a tick enable is high. A six-bit period value picks one bit of that timebase to watch. Each time the watched bit goes from 0 to 1, the watchdog moves one stage along a fixed escalation.

The escalation has three steps. The first edge raises a "next stage armed" flag. The second edge raises an interrupt flag, which drives an interrupt output when enabled. The third edge issues a one-cycle reset request of the kind held in a reset-kind field. That kind is also recorded as the reason for the last reset. Software keeps the watchdog quiet by writing ones to the two flags, which clears them.

A single register write port reaches two words, a control word and a status word. In the control word, the reset-kind field locks once it holds a non-zero value. A period of zero watches the top timebase bit, and the resulting interval is long enough that the watchdog is effectively off.

Top module: `tbw_watchdog`

## Requirements
- R1: The `timebase` output is 0 after reset. It increases by one on every clock edge where `tick_en` is high and holds its value otherwise.
- R2: The period value P selects timebase bit 63-P, so a 0→1 edge of the watched bit comes every 2^(64-P) ticks. In the control word, P[1:0] sits at bits [31:30] and P[5:2] sits at bits [20:17]. The interrupt enable is bit 27 and the reset kind is bits [29:28]. All other control bits read as 0.
- R3: A watched-bit edge while the armed flag (status bit 31) is clear sets that flag and changes nothing else.
- R4: A watched-bit edge while the armed flag is set and the interrupt flag (status bit 30) is clear sets the interrupt flag. `irq` equals interrupt flag AND interrupt enable, one cycle after either of them changes.
- R5: A watched-bit edge while both flags are set does two things when the reset kind is non-zero. It pulses `rst_req` high for exactly one cycle, and it copies the reset kind into the last-reset-reason field, status bits [29:28]. Code 0 in that field means no reset has been requested.
- R6: A write to the status word (`wr_addr`=1) clears each flag whose data bit is 1 and leaves each flag whose data bit is 0. The reason field ignores status writes.
- R7: The reset-kind field takes a written value only while it holds 0. Once it is non-zero, control writes leave it unchanged until reset.
- R8: Writing a new period never creates an edge by itself, even if the newly selected bit is already 1.
- R9: With period 0 (bit 63 watched), no escalation takes place while the timebase stays below 2^63.
- R10: After reset, the control word, the status word, `irq` and `rst_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advances the timebase by one when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 selects the status word |
| wr_data | input | 32 | Write data |
| timebase | output | 64 | Current timebase value |
| ctrl_q | output | 32 | Current control word |
| stat_q | output | 32 | Current status word |
| irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is a period change at a moment when the newly chosen bit is high but the previously sampled bit was low. A stale sample in that case would produce a false edge. The bench reaches it by counting ticks exactly: it stops the timebase at 14, where bit 1 is high and bit 0 is low, and then switches from watching bit 0 to watching bit 1. It then supplies four more ticks to confirm that the first genuine edge on bit 1 arrives only on the fourth of them.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register bit positions and types for the watchdog.
// Assumes a 32-bit register word; field positions are fixed by the software view.
package wdt_pkg;
    localparam int TB_W   = 64;
    localparam int PER_W  = 6;
    localparam int REG_W  = 32;
    localparam int KIND_W = 2;

    localparam int PLO_W         = 2;
    localparam int PHI_W         = PER_W - PLO_W;
    localparam int CTRL_PLO_LSB  = 30;
    localparam int CTRL_PHI_LSB  = 17;
    localparam int CTRL_IEN_BIT  = 27;
    localparam int CTRL_KIND_LSB = 28;

    localparam int STAT_ARM_BIT  = 31;
    localparam int STAT_INT_BIT  = 30;
    localparam int STAT_RSN_LSB  = 28;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } wdt_sel_e;

    typedef struct packed {
        logic [PER_W-1:0]  period;
        logic              ien;
        logic [KIND_W-1:0] kind;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_timebase.sv
`timescale 1ns/1ps
// Module: free-running timebase counter.
// Counts up by one per enabled tick; wraps naturally at 2^TB_W.
module wdt_timebase #(
    parameter int TB_W = wdt_pkg::TB_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    output logic [TB_W-1:0] tb
);
    // Advance the count on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       tb <= '0;
        else if (tick_en) tb <= tb + 1'b1;
    end

    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> tb == $past(tb) + 1'b1);                      // R1
    AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tb));                                // R1
endmodule

// File: rtl/wdt_ctrl_reg.sv
`timescale 1ns/1ps
// Module: control register holding the split period, interrupt enable and
// the lockable reset-kind field. Also presents the period that will be in
// force after this cycle, so the edge detector can resample on a change.
module wdt_ctrl_reg
    import wdt_pkg::*;
#(
    parameter int REG_W = wdt_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wr_data,
    output wdt_ctrl_t        ctrl,
    output logic [PER_W-1:0] period_nxt,
    output logic [REG_W-1:0] ctrl_word
);
    logic [PER_W-1:0] data_period;

    // Reassemble the period from its two separated data fields.
    always_comb begin
        data_period = {wr_data[CTRL_PHI_LSB +: PHI_W], wr_data[CTRL_PLO_LSB +: PLO_W]};
    end

    // Register update; the reset kind only accepts data while it is zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.period <= data_period;
            ctrl.ien    <= wr_data[CTRL_IEN_BIT];
            if (ctrl.kind == '0) ctrl.kind <= wr_data[CTRL_KIND_LSB +: KIND_W];
        end
    end

    // Period in force from the next cycle onward.
    always_comb begin
        period_nxt = wr_ctrl ? data_period : ctrl.period;
    end

    // Build the software-visible control word.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_PLO_LSB +: PLO_W]   = ctrl.period[PLO_W-1:0];
        ctrl_word[CTRL_PHI_LSB +: PHI_W]   = ctrl.period[PER_W-1:PLO_W];
        ctrl_word[CTRL_IEN_BIT]            = ctrl.ien;
        ctrl_word[CTRL_KIND_LSB +: KIND_W] = ctrl.kind;
    end

    AST_KIND_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.kind != '0) |=> $stable(ctrl.kind));                // R7
endmodule

// File: rtl/wdt_edge_det.sv
`timescale 1ns/1ps
// Module: picks timebase bit (TB_W-1-period) and flags its 0->1 edges.
// Assumes 2^PER_W <= TB_W. The sampled copy is taken with the upcoming
// period so a period change never looks like an edge.
module wdt_edge_det #(
    parameter int TB_W  = wdt_pkg::TB_W,
    parameter int PER_W = wdt_pkg::PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TB_W-1:0]  tb,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] period_nxt,
    output logic             edge_hit
);
    localparam int IDX_W = $clog2(TB_W);

    logic [IDX_W-1:0] idx_cur;
    logic [IDX_W-1:0] idx_nxt;
    logic             bit_cur;
    logic             bit_q;

    // Map period values to bit indices; higher period means a lower bit.
    always_comb begin
        idx_cur = IDX_W'(TB_W - 1) - IDX_W'(period);
        idx_nxt = IDX_W'(TB_W - 1) - IDX_W'(period_nxt);
        bit_cur = tb[idx_cur];
    end

    // Keep a sampled copy of the bit that will be watched next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= tb[idx_nxt];
    end

    // Rising edge of the watched bit.
    always_comb begin
        edge_hit = bit_cur & ~bit_q;
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |-> !$stable(tb));                               // R8
endmodule

// File: rtl/wdt_escalate.sv
`timescale 1ns/1ps
// Module: three-stage escalation with write-one-to-clear flags, the
// interrupt output and the reset request with its recorded reason.
// Status clears are applied before an edge in the same cycle is judged.
module wdt_escalate
    import wdt_pkg::*;
#(
    parameter int REG_W = wdt_pkg::REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_hit,
    input  logic              wr_stat,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ien,
    input  logic [KIND_W-1:0] kind,
    output logic              arm_q,
    output logic              int_q,
    output logic [KIND_W-1:0] reason_q,
    output logic              irq,
    output logic              rst_req
);
    logic arm_c, int_c, arm_n, int_n, fire;

    // Apply clears, then advance one stage on an edge.
    always_comb begin
        arm_c = arm_q & ~(wr_stat & wr_data[STAT_ARM_BIT]);
        int_c = int_q & ~(wr_stat & wr_data[STAT_INT_BIT]);
        arm_n = arm_c;
        int_n = int_c;
        fire  = 1'b0;
        if (edge_hit) begin
            if (!arm_c)      arm_n = 1'b1;
            else if (!int_c) int_n = 1'b1;
            else             fire  = (kind != '0);
        end
    end

    // Flag, reason and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q    <= 1'b0;
            int_q    <= 1'b0;
            reason_q <= '0;
            irq      <= 1'b0;
            rst_req  <= 1'b0;
        end else begin
            arm_q   <= arm_n;
            int_q   <= int_n;
            irq     <= int_q & ien;
            rst_req <= fire;
            if (fire) reason_q <= kind;
        end
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);                                    // R5
    AST_RST_AFTER_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(arm_q && int_q));                       // R5
    AST_RST_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> reason_q == $past(kind));                     // R5
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(int_q) && $past(ien));                      // R4
endmodule

// File: rtl/tbw_watchdog.sv
`timescale 1ns/1ps
// Module: top of the timebase-bit watchdog. Decodes the write port and joins
// the timebase, control register, edge detector and escalation stages.
// Assumes writes are single-cycle strobes; reads are the two word outputs.
module tbw_watchdog
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [TB_W-1:0]  timebase,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] stat_q,
    output logic             irq,
    output logic             rst_req
);
    logic              wr_ctrl, wr_stat, edge_hit, arm_q, int_q;
    logic [KIND_W-1:0] reason_q;
    logic [PER_W-1:0]  period_nxt;
    wdt_ctrl_t         ctrl;

    // Decode the write target.
    always_comb begin
        wr_ctrl = wr_en && (wdt_sel_e'(wr_addr) == SEL_CTRL);
        wr_stat = wr_en && (wdt_sel_e'(wr_addr) == SEL_STAT);
    end

    wdt_timebase #(.TB_W(TB_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb(timebase));

    wdt_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .ctrl(ctrl), .period_nxt(period_nxt), .ctrl_word(ctrl_q));

    wdt_edge_det #(.TB_W(TB_W), .PER_W(PER_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .tb(timebase), .period(ctrl.period),
        .period_nxt(period_nxt), .edge_hit(edge_hit));

    wdt_escalate #(.REG_W(REG_W)) u_esc (
        .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .wr_stat(wr_stat),
        .wr_data(wr_data), .ien(ctrl.ien), .kind(ctrl.kind),
        .arm_q(arm_q), .int_q(int_q), .reason_q(reason_q),
        .irq(irq), .rst_req(rst_req));

    // Build the software-visible status word.
    always_comb begin
        stat_q = '0;
        stat_q[STAT_ARM_BIT]            = arm_q;
        stat_q[STAT_INT_BIT]            = int_q;
        stat_q[STAT_RSN_LSB +: KIND_W]  = reason_q;
    end

    AST_PERIOD_WRITE_NO_ESCALATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !tick_en && $stable(timebase) && !wr_stat) |=> $stable(arm_q)); // R8
endmodule

// File: tb/test_tbw_watchdog.sv
`timescale 1ns/1ps
// Bench: vector table for the escalation sequence, then directed tests.
module test_tbw_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [63:0] timebase;
    logic [31:0] ctrl_q, stat_q;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;
    int rst_pulses = 0;
    int rst_long = 0;
    logic rst_prev = 1'b0;

    always #5 clk = ~clk;

    tbw_watchdog i_tbw_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .timebase(timebase),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .irq(irq), .rst_req(rst_req));

    // Count reset-request pulses and any that last more than one cycle.
    always @(posedge clk) begin
        if (rst_req) rst_pulses <= rst_pulses + 1;
        if (rst_req && rst_prev) rst_long <= rst_long + 1;
        rst_prev <= rst_req;
    end

    // op[38:37]: 0 edge event (two ticks), 1 control write, 2 status write
    // data[36:5], expected arm[4], int[3], irq[2], reason[1:0]
    localparam logic [38:0] VEC [0:8] = '{
        {2'd1, 32'hE81E_0000, 1'b0, 1'b0, 1'b0, 2'd0},
        {2'd0, 32'h0,         1'b1, 1'b0, 1'b0, 2'd0},
        {2'd0, 32'h0,         1'b1, 1'b1, 1'b1, 2'd0},
        {2'd2, 32'hC000_0000, 1'b0, 1'b0, 1'b0, 2'd0},
        {2'd0, 32'h0,         1'b1, 1'b0, 1'b0, 2'd0},
        {2'd2, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 2'd0},
        {2'd0, 32'h0,         1'b1, 1'b0, 1'b0, 2'd0},
        {2'd0, 32'h0,         1'b1, 1'b1, 1'b1, 2'd0},
        {2'd0, 32'h0,         1'b1, 1'b1, 1'b1, 2'd2}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
    endtask

    task automatic edge_event();
        tick();
        tick();
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic addr, input logic [31:0] data);
        @(negedge clk) begin wr_en = 1'b1; wr_addr = addr; wr_data = data; end
        @(negedge clk) begin wr_en = 1'b0; wr_data = '0; end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R1 timebase starts at zero
        chk("R10 ctrl", ctrl_q, 0);
        chk("R10 stat", stat_q, 0);
        chk("R10 irq", irq, 0);
        chk("R10 rst_req", rst_req, 0);
        chk("R1 timebase reset", timebase, 0);

        // Table walk: R3, R4, R5, R6 escalation and servicing
        for (int i = 0; i < 9; i++) begin
            logic [38:0] v;
            v = VEC[i];
            case (v[38:37])
                2'd0: edge_event();
                2'd1: wr(1'b0, v[36:5]);
                default: wr(1'b1, v[36:5]);
            endcase
            chk($sformatf("R3/R6 arm step %0d", i), stat_q[31], v[4]);
            chk($sformatf("R4/R6 int step %0d", i), stat_q[30], v[3]);
            chk($sformatf("R4 irq step %0d", i), irq, v[2]);
            chk($sformatf("R5 reason step %0d", i), stat_q[29:28], v[1:0]);
        end
        chk("R5 one reset pulse", rst_pulses, 1);
        chk("R5 pulse width", rst_long, 0);
        chk("R2 ctrl word", ctrl_q, 64'hE81E_0000);
        chk("R1 timebase count", timebase, 12);
        repeat (5) @(negedge clk);
        chk("R1 timebase hold", timebase, 12);

        // R6: status write must not touch the reason field
        wr(1'b1, 32'hF000_0000);
        chk("R6 reason kept", stat_q, 64'h2000_0000);

        // Bring timebase to 14 (bit1=1, bit0=0), then clear status
        edge_event();
        wr(1'b1, 32'hC000_0000);
        chk("R1 timebase at 14", timebase, 14);

        // R8: switch to period 62 (bit 1, already high); R7: kind write ignored
        wr(1'b0, 32'h981E_0000);
        repeat (3) @(negedge clk);
        chk("R8 no false edge", stat_q[31], 0);
        chk("R7 kind locked", ctrl_q, 64'hA81E_0000);

        // R2: bit 1 next rises at timebase 18, the fourth tick
        tick(); tick(); tick();
        repeat (3) @(negedge clk);
        chk("R2 bit1 not yet", stat_q[31], 0);
        tick();
        repeat (3) @(negedge clk);
        chk("R2 bit1 edge", stat_q[31], 1);

        // R9: period 0 watches bit 63
        wr(1'b1, 32'hC000_0000);
        wr(1'b0, 32'h0);
        chk("R7 kind kept on zero write", ctrl_q, 64'h2000_0000);
        for (int k = 0; k < 40; k++) tick();
        repeat (3) @(negedge clk);
        chk("R9 no escalation", stat_q[31:30], 0);

        // R4: interrupt flag without enable leaves irq low
        wr(1'b0, 32'hC01E_0000);
        edge_event();
        edge_event();
        chk("R4 int without enable", stat_q[30], 1);
        chk("R4 irq masked", irq, 0);
        chk("R5 no extra pulse", rst_pulses, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule